// File: doc/BRIEF.md
# DRAM Bank Timing Guard

This block keeps the per-bank timing rules of a DRAM device on behalf of a command scheduler. Each cycle it reports, for every bank, whether a row open (ACTIVATE), a column read (READ) or a row close (PRECHARGE) may be issued now. The scheduler presents at most one command per cycle. The guard accepts the command if it is legal at that moment, and it then restarts the timers of the addressed bank.

Each bank keeps its own open/closed state and four saturating down-counters. The first counts the row-to-column delay. The second counts the minimum row-active time. The third counts the read-to-close time. The fourth counts the close (precharge) time. A row may close only when both the row-active and the read-to-close windows have run out. A new row may open only after the close time, so one full row cycle on a bank lasts the row-active time plus the close time. A command that breaks a rule raises an error flag in the same cycle and leaves every bank unchanged. All timing values and the bank count are parameters.

Top module: `bank_guard`

## Requirements
- R1: After reset every bank is closed: all `actOk` bits are 1, all `rdOk` and `preOk` bits are 0, and `cmdError` is 0.
- R2: `cmdKind` encodes 0 = ACTIVATE, 1 = READ, 2 = PRECHARGE and 3 = no command. A command has an effect and can raise `cmdError` only while `cmdValid` is 1.
- R3: An accepted ACTIVATE in cycle c sets `rdOk` for that bank from cycle c+T_RCD onward, and it stays set until the bank is closed.
- R4: `preOk` for a bank is 1 only when the bank is open, at least T_RAS cycles have passed since its ACTIVATE, and at least T_RTP cycles have passed since its latest accepted READ. With T_RAS=18, T_RTP=4 and one READ at cycle 7, the first legal close is at cycle 18 after the ACTIVATE.
- R5: After an accepted PRECHARGE in cycle c, `actOk` for that bank returns at cycle c+T_RP. ACTIVATE to ACTIVATE on one bank is therefore at least T_RAS+T_RP cycles.
- R6: A command whose permission bit is 0 raises `cmdError` in the same cycle and is ignored. Bank state and timers stay as if no command had been presented.
- R7: Banks are independent. A command to one bank does not change the permissions of any other bank.
- R8: Each accepted READ restarts the read-to-close window, so a later READ pushes the earliest PRECHARGE out to T_RTP cycles after that READ.
- R9: `actOk` is 1 only for a closed bank, and `rdOk` and `preOk` are 1 only for an open bank. An ACTIVATE to an open bank or a PRECHARGE to a closed bank is an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdKind | input | 2 | Command code (0 open, 1 read, 2 close, 3 none) |
| cmdBank | input | BANK_W | Target bank index |
| actOk | output | NUM_BANKS | Per-bank ACTIVATE permission |
| rdOk | output | NUM_BANKS | Per-bank READ permission |
| preOk | output | NUM_BANKS | Per-bank PRECHARGE permission |
| cmdError | output | 1 | Presented command is illegal and ignored |

## Verification
The assertions assume that `cmdBank` always names an existing bank, and that `cmdKind` and `cmdBank` are stable and known whenever `cmdValid` is 1. The bench drives only bank indexes below NUM_BANKS. It changes inputs only on the falling clock edge. It deliberately presents illegal commands, such as an early READ, an early close, an early reopen, a close of a closed bank and an open of an open bank, so that the error path and its no-effect rule are exercised as well as legal traffic.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [1:0] {
    CMD_ACT  = 2'd0,
    CMD_READ = 2'd1,
    CMD_PRE  = 2'd2,
    CMD_NONE = 2'd3
  } cmdKind_e;

  // Issue strobes from the control to the per-bank timers.
  typedef struct packed {
    logic act;
    logic rd;
    logic pre;
  } cmdStrobe_t;

endpackage

// File: rtl/bank_guard_bank.sv
module bank_guard_bank #(
  parameter int T_RCD = 7,
  parameter int T_RAS = 18,
  parameter int T_RTP = 4,
  parameter int T_RP  = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic doAct,
  input  logic doRd,
  input  logic doPre,
  output logic actOk,
  output logic rdOk,
  output logic preOk
);
  localparam int MAX_A = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int MAX_B = (T_RTP > T_RP) ? T_RTP : T_RP;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);

  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RAS_LOAD = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] RTP_LOAD = CNT_W'(T_RTP - 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);

  logic             rowOpen;
  logic [CNT_W-1:0] rcdCnt, rasCnt, rtpCnt, rpCnt;

  function automatic logic [CNT_W-1:0] satDec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOpen <= 1'b0;
      rcdCnt  <= '0;
      rasCnt  <= '0;
      rtpCnt  <= '0;
      rpCnt   <= '0;
    end else begin
      if (doAct)      rowOpen <= 1'b1;
      else if (doPre) rowOpen <= 1'b0;
      rcdCnt <= doAct ? RCD_LOAD : satDec(rcdCnt);
      rasCnt <= doAct ? RAS_LOAD : satDec(rasCnt);
      rtpCnt <= doRd  ? RTP_LOAD : satDec(rtpCnt);
      rpCnt  <= doPre ? RP_LOAD  : satDec(rpCnt);
    end
  end

  assign actOk = !rowOpen && (rpCnt == '0);
  assign rdOk  = rowOpen && (rcdCnt == '0);
  assign preOk = rowOpen && (rasCnt == '0) && (rtpCnt == '0);

endmodule

// File: rtl/bank_guard_timers.sv
module bank_guard_timers
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 7,
  parameter int T_RAS     = 18,
  parameter int T_RTP     = 4,
  parameter int T_RP      = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdStrobe_t           strobe,
  input  logic [BANK_W-1:0]    cmdBank,
  output logic [NUM_BANKS-1:0] actOk,
  output logic [NUM_BANKS-1:0] rdOk,
  output logic [NUM_BANKS-1:0] preOk
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic hit;
    assign hit = (cmdBank == BANK_W'(b));

    bank_guard_bank #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RTP(T_RTP), .T_RP(T_RP)
    ) uBank (
      .clk   (clk),
      .rstN  (rstN),
      .doAct (hit && strobe.act),
      .doRd  (hit && strobe.rd),
      .doPre (hit && strobe.pre),
      .actOk (actOk[b]),
      .rdOk  (rdOk[b]),
      .preOk (preOk[b])
    );
  end

endmodule

// File: rtl/bank_guard_ctrl.sv
module bank_guard_ctrl
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 cmdValid,
  input  logic [1:0]           cmdKind,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [NUM_BANKS-1:0] actOk,
  input  logic [NUM_BANKS-1:0] rdOk,
  input  logic [NUM_BANKS-1:0] preOk,
  output cmdStrobe_t           strobe,
  output logic                 cmdError
);
  cmdKind_e kind;
  logic     isCmd;
  logic     allowed;

  always_comb begin
    kind    = cmdKind_e'(cmdKind);
    isCmd   = cmdValid && (kind != CMD_NONE);
    allowed = 1'b0;
    case (kind)
      CMD_ACT:  allowed = actOk[cmdBank];
      CMD_READ: allowed = rdOk[cmdBank];
      CMD_PRE:  allowed = preOk[cmdBank];
      default:  allowed = 1'b0;
    endcase
    strobe     = '0;
    strobe.act = isCmd && allowed && (kind == CMD_ACT);
    strobe.rd  = isCmd && allowed && (kind == CMD_READ);
    strobe.pre = isCmd && allowed && (kind == CMD_PRE);
    cmdError   = isCmd && !allowed;
  end

endmodule

// File: rtl/bank_guard.sv
module bank_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 7,
  parameter int T_RAS     = 18,
  parameter int T_RTP     = 4,
  parameter int T_RP      = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdKind,
  input  logic [BANK_W-1:0]    cmdBank,
  output logic [NUM_BANKS-1:0] actOk,
  output logic [NUM_BANKS-1:0] rdOk,
  output logic [NUM_BANKS-1:0] preOk,
  output logic                 cmdError
);
  cmdStrobe_t strobe;

  bank_guard_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .cmdValid (cmdValid),
    .cmdKind  (cmdKind),
    .cmdBank  (cmdBank),
    .actOk    (actOk),
    .rdOk     (rdOk),
    .preOk    (preOk),
    .strobe   (strobe),
    .cmdError (cmdError)
  );

  bank_guard_timers #(
    .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RTP(T_RTP), .T_RP(T_RP)
  ) uTimers (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdBank (cmdBank),
    .actOk   (actOk),
    .rdOk    (rdOk),
    .preOk   (preOk)
  );

endmodule

// File: rtl/bank_guard_chk.sv
module bank_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 7,
  parameter int T_RAS     = 18,
  parameter int T_RTP     = 4,
  parameter int T_RP      = 7,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic [1:0]           cmdKind,
  input logic [BANK_W-1:0]    cmdBank,
  input logic [NUM_BANKS-1:0] actOk,
  input logic [NUM_BANKS-1:0] rdOk,
  input logic [NUM_BANKS-1:0] preOk,
  input logic                 cmdError
);
  logic accepted;
  assign accepted = cmdValid && (cmdKind != 2'd3) && !cmdError;

  AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> !cmdError); // R2

  AST_OPEN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    ((actOk & (rdOk | preOk)) == '0)); // R9

  AST_ACT_CLOSES_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdKind == 2'd0) |=> !actOk[$past(cmdBank)]); // R9

  AST_PRE_ENDS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdKind == 2'd2) |=> (!rdOk[$past(cmdBank)] && !preOk[$past(cmdBank)])); // R4

  if (T_RCD > 1) begin : gRcd
    AST_RCD_WAIT: assert property (@(posedge clk) disable iff (!rstN)
      (accepted && cmdKind == 2'd0) |=> !rdOk[$past(cmdBank)]); // R3
  end

  if (T_RTP > 1) begin : gRtp
    AST_RTP_WAIT: assert property (@(posedge clk) disable iff (!rstN)
      (accepted && cmdKind == 2'd1) |=> !preOk[$past(cmdBank)]); // R8
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gHold
    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (rdOk[b] && !(accepted && cmdKind == 2'd2 && cmdBank == BANK_W'(b))) |=> rdOk[b]); // R3
  end

endmodule

bind bank_guard bank_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS),
  .T_RTP(T_RTP), .T_RP(T_RP)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdKind  (cmdKind),
  .cmdBank  (cmdBank),
  .actOk    (actOk),
  .rdOk     (rdOk),
  .preOk    (preOk),
  .cmdError (cmdError)
);

// File: tb/sim_bank_guard.sv
`timescale 1ns/1ps
module sim_bank_guard;
  localparam int NB    = 4;
  localparam int BW    = $clog2(NB);
  localparam int T_RCD = 7;
  localparam int T_RAS = 18;
  localparam int T_RTP = 4;
  localparam int T_RP  = 7;
  localparam logic [1:0] K_ACT = 2'd0, K_RD = 2'd1, K_PRE = 2'd2, K_NONE = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdKind = 2'd3;
  logic [BW-1:0] cmdBank = '0;
  logic [NB-1:0] actOk, rdOk, preOk;
  logic          cmdError;

  always #2 clk = ~clk;

  bank_guard #(.NUM_BANKS(NB), .T_RCD(T_RCD), .T_RAS(T_RAS),
               .T_RTP(T_RTP), .T_RP(T_RP)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .actOk(actOk), .rdOk(rdOk), .preOk(preOk),
    .cmdError(cmdError));

  typedef struct {
    logic [NB-1:0] a, r, p;
    logic          e;
    string         tag;
  } expItem_t;

  expItem_t sbq[$];
  int nCmp = 0, nBad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference model kept as timestamps of the latest accepted commands.
  bit isOpen[NB];
  int actT[NB], rdT[NB], preT[NB];

  initial begin
    for (int i = 0; i < NB; i++) begin
      isOpen[i] = 1'b0; actT[i] = -1000; rdT[i] = -1000; preT[i] = -1000;
    end
  end

  task automatic step(input logic v, input logic [1:0] k, input int bk, input string tag);
    expItem_t it;
    logic ok;
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      it.a[i] = !isOpen[i] && (cyc - preT[i] >= T_RP);
      it.r[i] = isOpen[i] && (cyc - actT[i] >= T_RCD);
      it.p[i] = isOpen[i] && (cyc - actT[i] >= T_RAS) && (cyc - rdT[i] >= T_RTP);
    end
    ok = (k == K_ACT) ? it.a[bk] : (k == K_RD) ? it.r[bk] : (k == K_PRE) ? it.p[bk] : 1'b0;
    it.e   = v && (k != K_NONE) && !ok;
    it.tag = tag;
    cmdValid = v; cmdKind = k; cmdBank = BW'(bk);
    sbq.push_back(it);
    if (v && k != K_NONE && ok) begin
      if (k == K_ACT) begin isOpen[bk] = 1'b1; actT[bk] = cyc; end
      if (k == K_RD)  rdT[bk] = cyc;
      if (k == K_PRE) begin isOpen[bk] = 1'b0; preT[bk] = cyc; end
    end
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, K_NONE, 0, tag);
  endtask

  task automatic cmpVec(input string tag, input string nm, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %b expected %b", tag, nm, act, exp);
    end
  endtask

  // Monitor: samples one time unit after the driving edge.
  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      cmpVec(it.tag, "actOk", actOk, it.a);
      cmpVec(it.tag, "rdOk", rdOk, it.r);
      cmpVec(it.tag, "preOk", preOk, it.p);
      cmpVec(it.tag, "cmdError", NB'(cmdError), NB'(it.e));
    end
  end

  initial begin
    #800000;
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(3, "R1");                         // reset state
    step(1'b1, K_ACT, 0, "R2");            // open bank 0
    step(1'b1, K_RD, 0, "R6");             // read too early: error, ignored
    idle(5, "R3");
    step(1'b1, K_RD, 0, "R3");             // first legal read
    step(1'b1, K_ACT, 1, "R7");            // other bank opens independently
    idle(6, "R7");
    step(1'b1, K_RD, 0, "R8");             // late read restarts read-to-close
    idle(2, "R8");
    step(1'b1, K_PRE, 0, "R4");            // row-active met, read window not: error
    step(1'b1, K_PRE, 0, "R4");            // both met: close
    step(1'b1, K_ACT, 0, "R5");            // reopen too early: error
    idle(5, "R5");
    step(1'b1, K_ACT, 0, "R5");            // close time elapsed
    step(1'b0, K_ACT, 2, "R2");            // not valid: no effect
    step(1'b1, K_PRE, 3, "R9");            // close of closed bank: error
    step(1'b1, K_ACT, 1, "R9");            // open of open bank: error
    step(1'b1, K_NONE, 2, "R2");           // no-command code
    idle(2, "R6");
    // Row-active window dominates: open, one read at +7, close at +18.
    step(1'b1, K_ACT, 2, "R4");
    for (int k = 1; k < 18; k++) begin
      if (k == 7)       step(1'b1, K_RD, 2, "R4");
      else if (k == 17) step(1'b1, K_PRE, 2, "R4");
      else              step(1'b0, K_NONE, 0, "R4");
    end
    step(1'b1, K_PRE, 2, "R4");
    step(1'b1, K_PRE, 1, "R7");
    idle(8, "R5");
    step(1'b1, K_ACT, 2, "R5");
    idle(4, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule